// File: doc/BRIEF.md
# Serial Port Status and Overrun Tracker

This block keeps the status byte of a clocked synchronous serial port. It follows a transfer-busy flag and a receive-overrun flag. The inputs are single-cycle event strobes from the shift engine and a power-enable bit. Software reads the status byte, and writes it through a byte-wide port with a per-bit write mask. Only the overrun flag takes software writes, and a write can only clear it.

The block also keeps an internal marker for received data that has not been read. The marker sets when a reception completes and clears when the CPU reads the receive buffer. An overrun happens when a reception starts while the marker is set. Each overrun raises a one-cycle reception error interrupt.

All flags are registered. Every event therefore shows at the outputs in the cycle after the clock edge that samples it. Dropping the power-enable bit returns the whole block to its reset state.

Top module: `ssr_status`

## Requirements
- R1: After reset `rd_data` reads 0x00, and status bits 6 to 1 read 0 at all times.
- R2: While `pwr_en` is low, the busy flag, the overrun flag and the unread-data marker are held at 0 from the next edge on. All event strobes and writes are ignored, and `rx_err_irq` stays 0.
- R3: A `tx_load` or `rx_dummy_rd` strobe sets the busy flag, which reads at bit 7 of `rd_data` from the next cycle.
- R4: A `last_sclk_edge` strobe clears the busy flag at the next edge. If a set strobe arrives in the same cycle, the flag stays set.
- R5: Software writes never change bit 7, whatever the data and mask.
- R6: A `rx_done` strobe sets the unread marker, and a `rx_cpu_rd` strobe clears it (`rx_done` wins if both arrive together). When `rx_start` comes while the marker is set, bit 0 (the overrun flag) sets at the next edge. When the marker is clear, `rx_start` has no effect.
- R7: `rx_err_irq` is high for exactly the cycle after each overrun event, in step with the overrun flag. It pulses again on every further overrun event, even when the flag is already 1.
- R8: A write with `wr_en` high, `wr_mask[0]` = 1 and `wr_data[0]` = 0 clears the overrun flag at the next edge. A write with `wr_data[0]` = 1, or with `wr_mask[0]` = 0, leaves the flag unchanged. A whole-byte write is a write with mask 0xFF.
- R9: If an overrun event and a software clear of the overrun flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| pwr_en | input | 1 | Interface power enable; low holds all status at 0 |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 8 | Write data |
| wr_mask | input | 8 | Per-bit write mask, 1 = bit written |
| rd_data | output | 8 | Status byte: bit 7 busy, bit 0 overrun, others 0 |
| tx_load | input | 1 | Transmit buffer was written |
| rx_dummy_rd | input | 1 | Dummy read of the receive buffer |
| last_sclk_edge | input | 1 | Final serial clock edge of a transfer |
| rx_start | input | 1 | A reception begins |
| rx_done | input | 1 | A reception completed |
| rx_cpu_rd | input | 1 | CPU read of the receive buffer |
| rx_err_irq | output | 1 | One-cycle reception error interrupt |

## Verification
The bench targets coincident strobes. It drives a set strobe together with `last_sclk_edge`, which a design with the wrong priority would leave idle. It also drives an overrun together with a software clear, which the same kind of error would let erase the flag. It repeats overruns while the flag is already set: a design that makes the interrupt follow the flag's rising edge would stay silent on the second one. It writes masked and whole-byte data with bit 0 at 1, which would expose a design that lets software set overrun or touch bit 7. It also checks that dropping power clears the unread marker, so that no later reception start is mistaken for an overrun.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  parameter int STAT_W   = 8;
  parameter int BUSY_POS = 7;
  parameter int OVR_POS  = 0;
endpackage

// File: rtl/ssr_busy_track.sv
module ssr_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set_tx,
  input  logic set_rx,
  input  logic clr_last,
  output logic busy
);
  logic busy_q;
  logic busy_d;
  logic busy_upd;
  logic set_any;

  always_comb begin
    set_any  = set_tx | set_rx;
    busy_upd = ~en | set_any | clr_last;
    if (!en)          busy_d = 1'b0;
    else if (set_any) busy_d = 1'b1;
    else              busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_q <= 1'b0;
    else if (busy_upd) busy_q <= busy_d;
  end

  assign busy = busy_q;
endmodule

// File: rtl/ssr_ovr_track.sv
module ssr_ovr_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rx_done,
  input  logic cpu_rd,
  input  logic rx_start,
  input  logic sw_clr,
  output logic ovr,
  output logic irq
);
  logic unread_q, unread_d, unread_upd;
  logic ovr_q, ovr_d, ovr_upd;
  logic irq_q, irq_d;
  logic ovr_evt;

  always_comb begin
    ovr_evt = en & rx_start & unread_q;

    unread_upd = ~en | rx_done | cpu_rd;
    if (!en)          unread_d = 1'b0;
    else if (rx_done) unread_d = 1'b1;
    else              unread_d = 1'b0;

    ovr_upd = ~en | ovr_evt | sw_clr;
    if (!en)          ovr_d = 1'b0;
    else if (ovr_evt) ovr_d = 1'b1;
    else              ovr_d = 1'b0;

    irq_d = ovr_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          unread_q <= 1'b0;
    else if (unread_upd) unread_q <= unread_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (ovr_upd) ovr_q <= ovr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign ovr = ovr_q;
  assign irq = irq_q;
endmodule

// File: rtl/ssr_reg_if.sv
module ssr_reg_if #(
  parameter int REG_W    = ssr_pkg::STAT_W,
  parameter int BUSY_POS = ssr_pkg::BUSY_POS,
  parameter int OVR_POS  = ssr_pkg::OVR_POS
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] wr_mask,
  input  logic             busy,
  input  logic             ovr,
  output logic             sw_ovr_clr,
  output logic [REG_W-1:0] rd_data
);
  always_comb begin
    sw_ovr_clr = wr_en & wr_mask[OVR_POS] & ~wr_data[OVR_POS];
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_rd
    if (i == BUSY_POS) begin : g_busy
      assign rd_data[i] = busy;
    end else if (i == OVR_POS) begin : g_ovr
      assign rd_data[i] = ovr;
    end else begin : g_zero
      assign rd_data[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ssr_status.sv
module ssr_status #(
  parameter int REG_W    = ssr_pkg::STAT_W,
  parameter int BUSY_POS = ssr_pkg::BUSY_POS,
  parameter int OVR_POS  = ssr_pkg::OVR_POS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] wr_mask,
  output logic [REG_W-1:0] rd_data,
  input  logic             tx_load,
  input  logic             rx_dummy_rd,
  input  logic             last_sclk_edge,
  input  logic             rx_start,
  input  logic             rx_done,
  input  logic             rx_cpu_rd,
  output logic             rx_err_irq
);
  logic busy;
  logic ovr;
  logic sw_ovr_clr;

  ssr_busy_track u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (pwr_en),
    .set_tx   (tx_load),
    .set_rx   (rx_dummy_rd),
    .clr_last (last_sclk_edge),
    .busy     (busy)
  );

  ssr_ovr_track u_ovr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (pwr_en),
    .rx_done  (rx_done),
    .cpu_rd   (rx_cpu_rd),
    .rx_start (rx_start),
    .sw_clr   (sw_ovr_clr),
    .ovr      (ovr),
    .irq      (rx_err_irq)
  );

  ssr_reg_if #(
    .REG_W    (REG_W),
    .BUSY_POS (BUSY_POS),
    .OVR_POS  (OVR_POS)
  ) u_regif (
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wr_mask    (wr_mask),
    .busy       (busy),
    .ovr        (ovr),
    .sw_ovr_clr (sw_ovr_clr),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/ssr_status_chk.sv
module ssr_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_en,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] wr_mask,
  input logic [7:0] rd_data,
  input logic       tx_load,
  input logic       rx_dummy_rd,
  input logic       last_sclk_edge,
  input logic       rx_start,
  input logic       rx_err_irq
);
  p_pwr_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> (rd_data == 8'h00) && !rx_err_irq);

  p_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en && (tx_load || rx_dummy_rd) |=> rd_data[7]);

  p_busy_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en && last_sclk_edge && !tx_load && !rx_dummy_rd |=> !rd_data[7]);

  p_busy_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !tx_load && !rx_dummy_rd && !last_sclk_edge && pwr_en |=> $stable(rd_data[7]));

  p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_irq |-> rd_data[0]);

  p_no_sw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] && !rx_start |=> !rd_data[0]);
endmodule

bind ssr_status ssr_status_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pwr_en         (pwr_en),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .wr_mask        (wr_mask),
  .rd_data        (rd_data),
  .tx_load        (tx_load),
  .rx_dummy_rd    (rx_dummy_rd),
  .last_sclk_edge (last_sclk_edge),
  .rx_start       (rx_start),
  .rx_err_irq     (rx_err_irq)
);

// File: tb/ssr_status_test.sv
`timescale 1ns/1ps
module ssr_status_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] wr_mask = 8'h00;
  logic [7:0] rd_data;
  logic       tx_load = 1'b0, rx_dummy_rd = 1'b0, last_sclk_edge = 1'b0;
  logic       rx_start = 1'b0, rx_done = 1'b0, rx_cpu_rd = 1'b0;
  logic       rx_err_irq;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model state
  bit m_busy, m_ovr, m_unread, m_irq, m_evt;

  always #2.5 clk = ~clk;

  ssr_status uut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .wr_en(wr_en),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_data(rd_data),
    .tx_load(tx_load), .rx_dummy_rd(rx_dummy_rd), .last_sclk_edge(last_sclk_edge),
    .rx_start(rx_start), .rx_done(rx_done), .rx_cpu_rd(rx_cpu_rd),
    .rx_err_irq(rx_err_irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !pwr_en) begin
      m_busy = 0; m_ovr = 0; m_unread = 0; m_irq = 0;
    end else begin
      m_evt = rx_start && m_unread;
      m_irq = m_evt;
      if (m_evt) m_ovr = 1;
      else if (wr_en && wr_mask[0] && !wr_data[0]) m_ovr = 0;
      if (tx_load || rx_dummy_rd) m_busy = 1;
      else if (last_sclk_edge) m_busy = 0;
      if (rx_done) m_unread = 1;
      else if (rx_cpu_rd) m_unread = 0;
    end
  end

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual {irq,rd}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_cmp();
    chk({phase, " model"}, {rx_err_irq, rd_data}, {m_irq, m_busy, 6'b0, m_ovr});
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_data = 8'h00; wr_mask = 8'h00;
    tx_load = 0; rx_dummy_rd = 0; last_sclk_edge = 0;
    rx_start = 0; rx_done = 0; rx_cpu_rd = 0;
  endtask

  // called at a negedge with inputs already driven
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_cmp();
    idle_inputs();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; pwr_en = 1;
    @(negedge clk);
    phase = "R1"; chk("R1 reset value", {rx_err_irq, rd_data}, 9'h000);

    phase = "R3"; tx_load = 1; tick();
    chk("R3 tx_load sets busy", {rx_err_irq, rd_data}, 9'h080);
    phase = "R5"; wr_en = 1; wr_data = 8'h00; wr_mask = 8'hFF; tick();
    chk("R5 write 0 to busy ignored", {rx_err_irq, rd_data}, 9'h080);
    phase = "R4"; last_sclk_edge = 1; tick();
    chk("R4 last edge clears busy", {rx_err_irq, rd_data}, 9'h000);
    phase = "R3"; rx_dummy_rd = 1; tick();
    chk("R3 dummy read sets busy", {rx_err_irq, rd_data}, 9'h080);
    phase = "R4"; last_sclk_edge = 1; tx_load = 1; tick();
    chk("R4 set wins over last edge", {rx_err_irq, rd_data}, 9'h080);
    last_sclk_edge = 1; tick();
    phase = "R5"; wr_en = 1; wr_data = 8'hFF; wr_mask = 8'hFF; tick();
    chk("R5 R1 R8 write FF idle", {rx_err_irq, rd_data}, 9'h000);

    phase = "R6"; rx_start = 1; tick();
    chk("R6 start without unread", {rx_err_irq, rd_data}, 9'h000);
    rx_done = 1; tick();
    rx_start = 1; tick();
    chk("R6 overrun sets flag and irq", {rx_err_irq, rd_data}, 9'h101);
    phase = "R7"; tick();
    chk("R7 irq single cycle", {rx_err_irq, rd_data}, 9'h001);
    rx_start = 1; tick();
    chk("R7 irq again with flag set", {rx_err_irq, rd_data}, 9'h101);

    phase = "R8"; wr_en = 1; wr_data = 8'h01; wr_mask = 8'h01; tick();
    chk("R8 write 1 keeps flag", {rx_err_irq, rd_data}, 9'h001);
    wr_en = 1; wr_data = 8'h00; wr_mask = 8'hFE; tick();
    chk("R8 masked bit ignored", {rx_err_irq, rd_data}, 9'h001);
    wr_en = 1; wr_data = 8'h00; wr_mask = 8'h01; tick();
    chk("R8 bit write 0 clears", {rx_err_irq, rd_data}, 9'h000);

    phase = "R6"; rx_cpu_rd = 1; tick();
    rx_start = 1; tick();
    chk("R6 cpu read clears unread", {rx_err_irq, rd_data}, 9'h000);
    rx_done = 1; rx_cpu_rd = 1; tick();
    rx_start = 1; tick();
    chk("R6 done wins over cpu read", {rx_err_irq, rd_data}, 9'h101);

    phase = "R8"; wr_en = 1; wr_data = 8'h00; wr_mask = 8'hFF; tick();
    chk("R8 byte write clears", {rx_err_irq, rd_data}, 9'h000);
    phase = "R9"; rx_start = 1; wr_en = 1; wr_data = 8'h00; wr_mask = 8'hFF; tick();
    chk("R9 set wins over sw clear", {rx_err_irq, rd_data}, 9'h101);

    phase = "R2"; tx_load = 1; tick();
    pwr_en = 0; tick();
    chk("R2 power off clears", {rx_err_irq, rd_data}, 9'h000);
    tx_load = 1; rx_done = 1; rx_start = 1; tick();
    chk("R2 events ignored when off", {rx_err_irq, rd_data}, 9'h000);
    pwr_en = 1; rx_start = 1; tick();
    chk("R2 unread cleared by power off", {rx_err_irq, rd_data}, 9'h000);

    phase = "R1"; rx_dummy_rd = 1; tick();
    rst_n = 0; #1;
    chk("R1 async reset clears", {rx_err_irq, rd_data}, 9'h000);
    @(negedge clk); rst_n = 1; tick();
    chk("R1 after reset", {rx_err_irq, rd_data}, 9'h000);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule